// File: doc/BRIEF.md
# Ethernet Receive Frame Capture

This block takes one received Ethernet frame at a time from the byte assembler behind the PHY and writes it into a local receive buffer of 32-bit words. The frame arrives as bytes with a valid strobe, a first-byte and a last-byte marker, and an error marker. Bytes are placed four to a word. While a frame arrives the block runs a CRC over it. On the clock edge that takes the last byte, it decides the outcome and updates a small set of status outputs, which stand in for the receive command register. A kept frame raises a level interrupt.

Capture is single-shot. Once a frame is kept, the receiver is held off until software pulses the clear input, and any frame that starts in the meantime is refused and counted as missed. Two option pins can disable the CRC check and keep the destination MAC. Each changes the stored layout, and both are sampled on the first byte of each frame. In the default layout the destination MAC is dropped, so that the payload starts on a word boundary. With the MAC kept, the EtherType is stored twice for the same reason. The buffer has a registered read port for software.

The byte stream has no back-pressure: a receiver cannot stall the wire, so there is no ready signal. A byte is taken or ignored in the cycle in which its valid strobe is high. A byte with valid high and the first marker clear is ignored unless a frame is in progress.

Top module: `eth_rx_capture`

## Requirements
- R1: Buffer byte position p lies in word p/4. Position p mod 4 = 0 is bits 31:24, 1 is bits 23:16, 2 is bits 15:8 and 3 is bits 7:0, so the earliest stored octet of a word sits in its top byte.
- R2: With cfg_mac_keep = 0, input octets 0 to 5 (destination MAC) are not stored, and input octet i (i >= 6) goes to position i-6. The source MAC then fills positions 0 to 5, the EtherType positions 6 to 7, and the payload starts at position 8.
- R3: With cfg_mac_keep = 1, input octets 0 to 13 go to positions 0 to 13, octets 12 and 13 are also written to positions 14 and 15, and input octet i (i >= 14) goes to position i+2.
- R4: A frame that ends without fault sets st_avail on the edge that takes its last byte. It also loads st_len with the stored length in octets: n-6 (MAC dropped) or n+2 (MAC kept) for an n-octet frame, less 4 when the CRC check is on. rx_irq is high exactly while st_avail is high.
- R5: While st_avail is high, a byte carrying the first marker sets st_missed on the next edge. That frame writes nothing to the buffer, and st_avail and st_len hold.
- R6: With cfg_crc_off = 0, a frame whose CRC-32 over all its octets, FCS included, does not leave the residue 0xDEBB20E3 sets st_crc_err and does not set st_avail.
- R7: With cfg_crc_off = 1, no CRC is checked and the 4 FCS octets count in st_len.
- R8: A frame with in_err high on any of its taken bytes sets st_gen_err and does not set st_avail. A frame shorter than 14 octets (18 with the CRC check on) has the same outcome.
- R9: A kept frame whose first six octets are all 0xFF sets st_bcast together with st_avail.
- R10: A kept frame whose stored length would exceed the buffer capacity (4 x DEPTH octets) sets st_avail with st_len equal to the capacity, and also sets st_gen_err. Positions beyond the capacity are never written.
- R11: A cycle with sw_clear high and no valid byte makes st_avail, st_missed, st_crc_err, st_gen_err, st_bcast, st_len and rx_irq all zero after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Received octet |
| in_first | input | 1 | Octet is the first of a frame |
| in_last | input | 1 | Octet is the last of a frame |
| in_err | input | 1 | Receive fault on this octet |
| cfg_crc_off | input | 1 | 1 disables the CRC check and keeps the FCS |
| cfg_mac_keep | input | 1 | 1 keeps the destination MAC (doubled EtherType layout) |
| sw_clear | input | 1 | Re-arm pulse; clears the status |
| rd_addr | input | ADDR_W | Buffer word read address |
| rd_data | output | 32 | Buffer word, one cycle after rd_addr |
| st_avail | output | 1 | A kept frame is waiting |
| st_len | output | LEN_W | Stored length in octets |
| st_missed | output | 1 | A frame was refused while busy |
| st_crc_err | output | 1 | A frame failed the CRC check |
| st_gen_err | output | 1 | Fault, runt or truncated frame |
| st_bcast | output | 1 | Kept frame had a broadcast destination |
| rx_irq | output | 1 | Receive interrupt, level |

## Verification
A wrong byte index or layout choice shows up as shifted or doubled octets in the buffer words, which are read back right after each kept frame. A wrong CRC register or length count shows up in the same cycle the last byte is taken, as a wrong flag or a wrong st_len. The bench compares every status output with its model on every clock, so a flag set one cycle late or early is caught at once. A hold-off fault, where a refused frame is stored anyway, shows up as a buffer image that changed after a missed frame, or as a len that moved while st_avail was high.

// File: rtl/eth_rx_pkg.sv
`timescale 1ns/1ps
package eth_rx_pkg;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef struct packed {
    logic avail;
    logic missed;
    logic crc_err;
    logic gen_err;
    logic bcast;
  } rx_flags_t;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_crc32.sv
`timescale 1ns/1ps
module rx_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        first,
  input  logic [7:0]  data,
  output logic [31:0] crc_nx
);
  import eth_rx_pkg::*;
  logic [31:0] crc_q;

  // The first byte seeds from all-ones, so a frame never sees its predecessor.
  assign crc_nx = crc32_byte(first ? 32'hFFFF_FFFF : crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_nx;
  end
endmodule

// File: rtl/rx_byte_placer.sv
`timescale 1ns/1ps
module rx_byte_placer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6,
  parameter int CAP    = 256
) (
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        data,
  input  logic              keep,
  input  logic              take,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [3:0]        be,
  output logic [31:0]       wdata
);
  localparam int PW = CNT_W + 2;

  logic [PW-1:0] idx_w, pos0, pos1;
  logic          store, dual;

  function automatic logic [3:0] lane(input logic [1:0] p);
    return 4'b1000 >> p;
  endfunction

  always_comb begin
    idx_w = {2'b00, idx};
    if (keep) pos0 = (idx_w < PW'(14)) ? idx_w : idx_w + PW'(2);
    else      pos0 = idx_w - PW'(6);
    pos1  = pos0 + PW'(2);
    store = keep || (idx_w >= PW'(6));
    // EtherType octets are written a second time two positions on, same word.
    dual  = keep && ((idx_w == PW'(12)) || (idx_w == PW'(13)));
    we    = take && store && (pos0 < PW'(CAP));
    addr  = pos0[ADDR_W+1:2];
    be    = lane(pos0[1:0]) | (dual ? lane(pos1[1:0]) : 4'b0000);
    wdata = {4{data}};
  end
endmodule

// File: rtl/rx_buffer.sv
`timescale 1ns/1ps
module rx_buffer #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [31:0]       rdata
);
  logic [31:0] mem [DEPTH];

  for (genvar l = 0; l < 4; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && be[l]) mem[waddr][8*l +: 8] <= wdata[8*l +: 8];
    end
  end

  always_ff @(posedge clk) rdata <= mem[raddr];
endmodule

// File: rtl/rx_frame_ctrl.sv
`timescale 1ns/1ps
module rx_frame_ctrl #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 9,
  parameter int CAP   = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  input  logic             in_err,
  input  logic             cfg_crc_off,
  input  logic             cfg_mac_keep,
  input  logic             sw_clear,
  input  logic [31:0]      crc_nx,
  output logic             take,
  output logic             take_first,
  output logic [CNT_W-1:0] idx_cur,
  output logic             keep_eff,
  output eth_rx_pkg::rx_flags_t flags,
  output logic [LEN_W-1:0] len
);
  import eth_rx_pkg::*;
  localparam int NW = CNT_W + 1;
  localparam int PW = CNT_W + 2;

  logic             active, err_q, bcast_q, keep_q, crcoff_q;
  logic [CNT_W-1:0] idx_q;
  logic             crc_on, err_fin, runt, crc_bad, over, fin, bcast_nx;
  logic [NW-1:0]    n;
  logic [PW-1:0]    lraw, lfin;
  rx_flags_t        flags_nx;
  logic [LEN_W-1:0] len_nx;

  always_comb begin
    take_first = in_valid && in_first && !flags.avail;
    take       = take_first || (in_valid && !in_first && active);
    idx_cur    = in_first ? '0 : idx_q;
    keep_eff   = in_first ? cfg_mac_keep : keep_q;
    crc_on     = !(in_first ? cfg_crc_off : crcoff_q);
    n          = {1'b0, idx_cur} + NW'(1);
    lraw       = keep_eff ? {1'b0, n} + PW'(2) : {1'b0, n} - PW'(6);
    lfin       = lraw - (crc_on ? PW'(4) : PW'(0));
    over       = lfin > PW'(CAP);
    runt       = n < (crc_on ? NW'(18) : NW'(14));
    err_fin    = (!in_first && err_q) || in_err;
    crc_bad    = crc_on && (crc_nx != CRC_RESIDUE);
    bcast_nx   = (in_first ? 1'b1 : bcast_q) &&
                 ((idx_cur >= CNT_W'(6)) || (in_data == 8'hFF));
    fin        = take && in_last;

    flags_nx = sw_clear ? '0 : flags;
    len_nx   = sw_clear ? '0 : len;
    if (in_valid && in_first && flags.avail) flags_nx.missed = 1'b1;
    if (fin) begin
      if (err_fin || runt)  flags_nx.gen_err = 1'b1;
      else if (crc_bad)     flags_nx.crc_err = 1'b1;
      else begin
        flags_nx.avail = 1'b1;
        flags_nx.bcast = flags_nx.bcast | bcast_q;
        if (over) begin
          flags_nx.gen_err = 1'b1;
          len_nx = LEN_W'(CAP);
        end else begin
          len_nx = lfin[LEN_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      err_q    <= 1'b0;
      bcast_q  <= 1'b0;
      keep_q   <= 1'b0;
      crcoff_q <= 1'b0;
      idx_q    <= '0;
      flags    <= '0;
      len      <= '0;
    end else begin
      flags <= flags_nx;
      len   <= len_nx;
      if (take) begin
        idx_q   <= (idx_cur == '1) ? idx_cur : idx_cur + CNT_W'(1);
        err_q   <= err_fin;
        bcast_q <= bcast_nx;
        active  <= !in_last;
      end
      if (take_first) begin
        keep_q   <= cfg_mac_keep;
        crcoff_q <= cfg_crc_off;
      end
    end
  end
endmodule

// File: rtl/eth_rx_capture.sv
`timescale 1ns/1ps
module eth_rx_capture #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH*4 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              in_err,
  input  logic              cfg_crc_off,
  input  logic              cfg_mac_keep,
  input  logic              sw_clear,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              st_avail,
  output logic [LEN_W-1:0]  st_len,
  output logic              st_missed,
  output logic              st_crc_err,
  output logic              st_gen_err,
  output logic              st_bcast,
  output logic              rx_irq
);
  import eth_rx_pkg::*;
  localparam int CAP = DEPTH * 4;

  logic             take, take_first, keep_eff, mem_we;
  logic [CNT_W-1:0] idx_cur;
  logic [31:0]      crc_nx, mem_wdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]       mem_be;
  rx_flags_t        flags;

  rx_frame_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W), .CAP(CAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_err(in_err),
    .cfg_crc_off(cfg_crc_off), .cfg_mac_keep(cfg_mac_keep), .sw_clear(sw_clear),
    .crc_nx(crc_nx), .take(take), .take_first(take_first), .idx_cur(idx_cur),
    .keep_eff(keep_eff), .flags(flags), .len(st_len)
  );

  rx_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .en(take), .first(take_first),
    .data(in_data), .crc_nx(crc_nx)
  );

  rx_byte_placer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CAP(CAP)) u_place (
    .idx(idx_cur), .data(in_data), .keep(keep_eff), .take(take),
    .we(mem_we), .addr(mem_addr), .be(mem_be), .wdata(mem_wdata)
  );

  rx_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .be(mem_be), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign st_avail   = flags.avail;
  assign st_missed  = flags.missed;
  assign st_crc_err = flags.crc_err;
  assign st_gen_err = flags.gen_err;
  assign st_bcast   = flags.bcast;
  assign rx_irq     = flags.avail;
endmodule

// File: rtl/eth_rx_capture_chk.sv
`timescale 1ns/1ps
module eth_rx_capture_chk #(
  parameter int CAP   = 256,
  parameter int LEN_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_first,
  input logic             in_last,
  input logic             sw_clear,
  input logic             st_avail,
  input logic [LEN_W-1:0] st_len,
  input logic             st_missed,
  input logic             st_crc_err,
  input logic             st_gen_err,
  input logic             st_bcast,
  input logic             rx_irq,
  input logic             buf_we
);
  // R4: availability only appears on the edge that takes a last byte
  p_avail_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_avail) |-> $past(in_valid && in_last));

  // R5: held frame and its length stay put until a clear
  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_avail && !sw_clear |=> st_avail && $stable(st_len));

  // R5: no buffer write while a frame is held
  p_no_write_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_avail |-> !buf_we);

  // R5: a frame starting while busy is recorded as missed
  p_missed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_avail && in_valid && in_first |=> st_missed);

  // R6: a CRC failure never keeps the frame
  p_crc_no_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_crc_err) |-> !$rose(st_avail));

  // R10: reported length never exceeds capacity
  p_len_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_len <= LEN_W'(CAP));

  // R11: clear empties the status one cycle later
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear && !in_valid |=> !st_avail && !st_missed && !st_crc_err &&
                              !st_gen_err && !st_bcast && !rx_irq && st_len == '0);
endmodule

bind eth_rx_capture eth_rx_capture_chk #(.CAP(CAP), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .in_last(in_last), .sw_clear(sw_clear), .st_avail(st_avail), .st_len(st_len),
  .st_missed(st_missed), .st_crc_err(st_crc_err), .st_gen_err(st_gen_err),
  .st_bcast(st_bcast), .rx_irq(rx_irq), .buf_we(mem_we)
);

// File: tb/tb_eth_rx_capture.sv
`timescale 1ns/1ps
module tb_eth_rx_capture;
  localparam int DEPTH = 64;
  localparam int CAP   = DEPTH * 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH*4 + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_first = 0, in_last = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic cfg_crc_off = 0, cfg_mac_keep = 0, sw_clear = 0;
  logic [AW-1:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic st_avail, st_missed, st_crc_err, st_gen_err, st_bcast, rx_irq;
  logic [LW-1:0] st_len;

  always #2.5 clk = ~clk;

  eth_rx_capture #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_err(in_err),
    .cfg_crc_off(cfg_crc_off), .cfg_mac_keep(cfg_mac_keep), .sw_clear(sw_clear),
    .rd_addr(rd_addr), .rd_data(rd_data), .st_avail(st_avail), .st_len(st_len),
    .st_missed(st_missed), .st_crc_err(st_crc_err), .st_gen_err(st_gen_err),
    .st_bcast(st_bcast), .rx_irq(rx_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;
  int m_avail = 0, m_missed = 0, m_crc = 0, m_err = 0, m_bcast = 0, m_len = 0;
  byte unsigned fr[$];
  byte unsigned img[$];

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk(int'(st_avail),   m_avail,  "R4 st_avail");
    chk(int'(rx_irq),     m_avail,  "R4 rx_irq level");
    chk(int'(st_len),     m_len,    "R4 st_len");
    chk(int'(st_missed),  m_missed, "R5 st_missed");
    chk(int'(st_crc_err), m_crc,    "R6 st_crc_err");
    chk(int'(st_gen_err), m_err,    "R8 st_gen_err");
    chk(int'(st_bcast),   m_bcast,  "R9 st_bcast");
  end

  function automatic bit [31:0] crc_of(input byte unsigned q[$]);
    bit [31:0] c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      c = c ^ {24'd0, q[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // destination, source, EtherType 0x0800, payload, then FCS low byte first
  task automatic build(input bit bcast, input int npay, input int seed, input bit corrupt);
    bit [31:0] f;
    fr.delete();
    for (int i = 0; i < 6; i++) fr.push_back(bcast ? 8'hFF : byte'(8'h10 + i));
    for (int i = 0; i < 6; i++) fr.push_back(byte'(8'hA0 + i + seed));
    fr.push_back(8'h08); fr.push_back(8'h00);
    for (int i = 0; i < npay; i++) fr.push_back(byte'(i * 7 + seed));
    f = crc_of(fr);
    for (int i = 0; i < 4; i++) fr.push_back(f[8*i +: 8]);
    if (corrupt) fr[20] = fr[20] ^ 8'h5A;
  endtask

  task automatic send(input int err_at, input bit corrupt, input bit bc);
    int n = fr.size();
    bit ignored = 0;
    bit crc_on = !cfg_crc_off;
    int lfin;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = fr[i]; in_first = (i == 0);
      in_last = (i == n-1); in_err = (i == err_at);
      @(posedge clk);
      if (i == 0 && m_avail != 0) begin m_missed = 1; ignored = 1; end
      if (i == n-1 && !ignored) begin
        if (err_at >= 0 || n < (crc_on ? 18 : 14)) m_err = 1;
        else if (crc_on && corrupt) m_crc = 1;
        else begin
          lfin = (cfg_mac_keep ? n + 2 : n - 6) - (crc_on ? 4 : 0);
          m_avail = 1;
          if (bc) m_bcast = 1;
          if (lfin > CAP) begin m_err = 1; m_len = CAP; end
          else m_len = lfin;
          img.delete();
          if (cfg_mac_keep) begin
            for (int j = 0; j < 14; j++) img.push_back(fr[j]);
            img.push_back(fr[12]); img.push_back(fr[13]);
            for (int j = 14; j < n; j++) img.push_back(fr[j]);
          end else
            for (int j = 6; j < n; j++) img.push_back(fr[j]);
        end
      end
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0; in_err = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); sw_clear = 1;
    @(posedge clk);
    m_avail = 0; m_missed = 0; m_crc = 0; m_err = 0; m_bcast = 0; m_len = 0;
    @(negedge clk); sw_clear = 0;
    chk(int'(st_avail | st_missed | st_crc_err | st_gen_err | st_bcast | rx_irq),
        0, "R11 flags after clear");
  endtask

  task automatic check_mem(input int len, input string tag);
    for (int k = 0; k < (len + 3) / 4; k++) begin
      int bad = -1;
      @(negedge clk); rd_addr = AW'(k);
      @(posedge clk); #1;
      for (int j = 0; j < 4; j++)
        if (4*k + j < len && rd_data[31-8*j -: 8] != img[4*k+j]) bad = j;
      n_chk++;
      if (bad >= 0) begin
        n_fail++;
        $display("FAIL %s word %0d actual=%h expected byte%0d=%h", tag, k, rd_data,
                 bad, img[4*k+bad]);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk(int'(st_avail | st_len | rx_irq | st_missed | st_crc_err | st_gen_err | st_bcast),
        0, "R4 reset state");
    cmp_en = 1;

    // default layout, CRC on: 64-octet frame -> 54 stored
    build(0, 46, 3, 0); send(-1, 0, 0);
    chk(int'(st_len), 54, "R4 R7 length excludes FCS");
    check_mem(m_len, "R1 R2 stripped layout");

    // busy: refused, buffer untouched
    build(0, 30, 9, 0); send(-1, 0, 0);
    check_mem(m_len, "R5 buffer unchanged after missed frame");
    do_clear();

    // CRC failure
    build(0, 46, 5, 1); send(-1, 1, 0);
    chk(int'(st_avail), 0, "R6 bad CRC not kept");
    do_clear();

    // MAC kept, CRC off: 68-octet frame -> 70 stored
    cfg_mac_keep = 1; cfg_crc_off = 1;
    build(0, 50, 11, 0); send(-1, 0, 0);
    chk(int'(st_len), 70, "R3 R7 length with FCS");
    check_mem(m_len, "R1 R3 doubled EtherType layout");
    do_clear();

    // broadcast
    cfg_mac_keep = 0; cfg_crc_off = 0;
    build(1, 46, 17, 0); send(-1, 0, 1);
    chk(int'(st_bcast), 1, "R9 broadcast flag");
    check_mem(m_len, "R2 broadcast frame layout");
    do_clear();

    // receive fault, then runt, then a good frame still accepted
    build(0, 46, 21, 0); send(20, 0, 0);
    chk(int'(st_gen_err), 1, "R8 receive fault");
    fr.delete();
    for (int i = 0; i < 10; i++) fr.push_back(byte'(i));
    send(-1, 0, 0);
    chk(int'(st_avail), 0, "R8 runt not kept");
    build(0, 46, 23, 0); send(-1, 0, 0);
    check_mem(m_len, "R2 good frame after faults");
    do_clear();

    // oversize: 300 octets -> truncated to capacity
    build(0, 282, 29, 0); send(-1, 0, 0);
    chk(int'(st_len), CAP, "R10 truncated length");
    check_mem(CAP, "R10 truncated content");
    do_clear();

    // default layout, CRC off: 64 octets -> 58 stored
    cfg_crc_off = 1;
    build(0, 46, 31, 0); send(-1, 0, 0);
    chk(int'(st_len), 58, "R7 FCS kept in length");
    check_mem(m_len, "R7 FCS stored");
    do_clear();

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule